// File: doc/BRIEF.md
# SDRAM Burst Data-Phase Timer

This block keeps the burst settings that a memory controller programs into an SDRAM mode register. From them it produces the data-phase timing for each column command. A read start goes through a latency pipe that matches the programmed CAS latency. A data-valid window then opens and lasts for the burst length. A write start opens a data-accept window at once, in the cycle of the command itself. While either window is open, the block presents the column address of the current beat, in sequential or interleaved order. One cycle after the final beat it raises a single-cycle burst-done pulse.

Full-page bursts run around the 512-column page until a terminate input stops them. A terminate input also cuts any shorter burst short. A write-mode bit makes writes single-beat while reads keep the programmed length. Command decoding and bank bookkeeping belong to the controller around this block.

Top module: `sdr_beat_timer`

## Requirements
- R1: After reset `rd_valid`, `wr_accept` and `burst_done` are low, and the settings are burst length 1, CAS latency 3, sequential order and normal writes.
- R2: A `mode_load` pulse stores all four fields at once. The `mode_bl` codes are 0→1, 1→2, 2→4 and 3→8 beats, with 7 meaning full page. `mode_cl` gives the latency in clocks (1, 2 or 3). A load that carries `mode_bl` 4, 5 or 6, or `mode_cl` 0, changes nothing.
- R3: For a read sampled at clock edge E0, `rd_valid` is high on the L outputs that follow edges E(CL-1) to E(CL+L-2), where L is the burst length. It is low otherwise.
- R4: For a write, `wr_accept` is high during the command cycle itself and then for the L-1 cycles after edge E0.
- R5: With `mode_ilv`=0, beat i of a burst of length L from start column S shows column (S with its low log2(L) bits replaced by (S+i) mod L).
- R6: With `mode_ilv`=1 and L of 8 or less, beat i shows S with its low log2(L) bits XORed with i.
- R7: A full-page burst shows (S+i) mod 512 in either order type and continues until `burst_term` ends it.
- R8: When `burst_term` is high during an open beat, that beat is the last of the burst.
- R9: With `mode_single_wr`=1, a write accepts exactly one beat, and reads still use the programmed length.
- R10: `burst_done` is high for exactly the one cycle that follows the last beat of each burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Store the mode fields below |
| mode_bl | input | 3 | Burst length code |
| mode_cl | input | 2 | CAS latency in clocks |
| mode_ilv | input | 1 | 1 selects interleaved beat order |
| mode_single_wr | input | 1 | 1 makes writes single-beat |
| rd_start | input | 1 | Read column command |
| wr_start | input | 1 | Write column command |
| start_col | input | 9 | Starting column of the command |
| burst_term | input | 1 | Ends the running burst after this beat |
| rd_valid | output | 1 | Read data beat on the bus |
| wr_accept | output | 1 | Write data beat taken |
| beat_col | output | 9 | Column of the current beat |
| burst_done | output | 1 | One-cycle pulse after the last beat |

## Verification
A read's first `rd_valid` comes CL-1 edges after the edge that samples the command. `wr_accept` and the first write column are combinational from `wr_start`, and later write beats follow one per edge. `burst_done` comes one edge after the last beat. The bench numbers each cycle relative to the command edge (the command cycle is -1) and drives inputs on the falling edge. It samples one nanosecond later, so every check lands mid-cycle in the exact period its requirement names, including terminate points placed inside full-page bursts.

// File: rtl/sdr_beat_pkg.sv
package sdr_beat_pkg;

   typedef struct packed {
      logic [2:0] bl_code;
      logic [1:0] cl;
      logic       ilv;
      logic       single_wr;
   } sdr_mode_t;

   localparam logic [2:0] BL_FULL_CODE = 3'd7;

   function automatic logic bl_code_legal(input logic [2:0] code);
      return (code <= 3'd3) || (code == BL_FULL_CODE);
   endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
   import sdr_beat_pkg::*;
#(
   parameter int LAT_MAX = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [2:0] bl_code,
   input  logic [1:0] cl,
   input  logic       ilv,
   input  logic       single_wr,
   output sdr_mode_t  mode
);
   localparam logic [1:0] CL_RESET = 2'(LAT_MAX);

   logic accept;
   assign accept = load && bl_code_legal(bl_code) && (cl != 2'd0)
                   && (int'(cl) <= LAT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode.bl_code   <= 3'd0;
         mode.cl        <= CL_RESET;
         mode.ilv       <= 1'b0;
         mode.single_wr <= 1'b0;
      end else if (accept) begin
         mode.bl_code   <= bl_code;
         mode.cl        <= cl;
         mode.ilv       <= ilv;
         mode.single_wr <= single_wr;
      end
   end

   p_cl_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.cl != 2'd0) && bl_code_legal(mode.bl_code));

   p_bad_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !bl_code_legal(bl_code)) |=> $stable(mode));

endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe #(
   parameter int COL_W   = 9,
   parameter int LAT_MAX = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cl,
   input  logic             rd_start,
   input  logic [COL_W-1:0] start_col,
   output logic             launch,
   output logic [COL_W-1:0] launch_col
);
   localparam int DEPTH = LAT_MAX - 1;

   generate
      if (DEPTH == 0) begin : g_bypass
         assign launch     = rd_start;
         assign launch_col = start_col;
      end else begin : g_pipe
         logic             sv [DEPTH];
         logic [COL_W-1:0] sc [DEPTH];

         for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_head
               always_ff @(posedge clk) begin
                  if (!rst_n) sv[0] <= 1'b0;
                  else        sv[0] <= rd_start;
                  sc[0] <= start_col;
               end
            end else begin : g_body
               always_ff @(posedge clk) begin
                  if (!rst_n) sv[s] <= 1'b0;
                  else        sv[s] <= sv[s-1];
                  sc[s] <= sc[s-1];
               end
            end
         end

         always_comb begin
            launch     = 1'b0;
            launch_col = '0;
            if (cl == 2'd1) begin
               launch     = rd_start;
               launch_col = start_col;
            end else begin
               for (int i = 0; i < DEPTH; i++) begin
                  if (int'(cl) == i + 2) begin
                     launch     = sv[i];
                     launch_col = sc[i];
                  end
               end
            end
         end

         p_cl2_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rd_start) && cl == 2'd2 && $stable(cl)) |-> launch);
      end
   endgenerate

   p_cl1_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cl == 2'd1 && rd_start) |-> (launch && launch_col == start_col));

endmodule

// File: rtl/sdr_beat_seq.sv
module sdr_beat_seq #(
   parameter int COL_W  = 9,
   parameter bit ILV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bl_code,
   input  logic             ilv,
   input  logic             single_wr,
   input  logic             rd_launch,
   input  logic [COL_W-1:0] rd_col,
   input  logic             wr_start,
   input  logic [COL_W-1:0] wr_col,
   input  logic             term,
   output logic             rd_valid,
   output logic             wr_accept,
   output logic [COL_W-1:0] beat_col,
   output logic             burst_done
);
   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   logic             act, is_wr, done;
   logic [COL_W-1:0] base, idx, mask, cur_col, seq_col;
   logic             full, wr_one, idx_last;

   assign full   = (bl_code == 3'd7);
   assign wr_one = single_wr || (bl_code == 3'd0);

   always_comb begin
      case (bl_code)
         3'd0:    mask = '0;
         3'd1:    mask = COL_W'(1);
         3'd2:    mask = COL_W'(3);
         3'd3:    mask = COL_W'(7);
         default: mask = '1;
      endcase
   end

   assign idx_last = !full && (idx == mask);
   assign seq_col  = (base & ~mask) | ((base + idx) & mask);

   generate
      if (ILV_EN) begin : g_ilv
         assign cur_col = (ilv && !full) ? ((base & ~mask) | ((base ^ idx) & mask))
                                         : seq_col;
      end else begin : g_seq_only
         logic unused_ilv;
         assign unused_ilv = ilv;
         assign cur_col    = seq_col;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act   <= 1'b0;
         is_wr <= 1'b0;
         done  <= 1'b0;
         base  <= '0;
         idx   <= '0;
      end else if (wr_start) begin
         base  <= wr_col;
         idx   <= ONE;
         is_wr <= 1'b1;
         act   <= !(wr_one || term);
         done  <= wr_one || term;
      end else if (rd_launch) begin
         base  <= rd_col;
         idx   <= '0;
         is_wr <= 1'b0;
         act   <= 1'b1;
         done  <= 1'b0;
      end else if (act) begin
         if (term || idx_last) begin
            act  <= 1'b0;
            done <= 1'b1;
         end else begin
            idx  <= idx + ONE;
            done <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end

   assign rd_valid   = act && !is_wr;
   assign wr_accept  = wr_start || (act && is_wr);
   assign beat_col   = wr_start ? wr_col : cur_col;
   assign burst_done = done;

   p_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> (((cur_col ^ base) & ~mask) == '0));

   p_single_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && single_wr) |=> !(act && is_wr));

   p_fullpage_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act && full && !term && !wr_start && !rd_launch) |=> act);

   p_term_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (act && term && !wr_start && !rd_launch) |=> (!act && done));

endmodule

// File: rtl/sdr_beat_timer.sv
module sdr_beat_timer
   import sdr_beat_pkg::*;
#(
   parameter int COL_W   = 9,
   parameter int LAT_MAX = 3,
   parameter bit ILV_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_load,
   input  logic [2:0]       mode_bl,
   input  logic [1:0]       mode_cl,
   input  logic             mode_ilv,
   input  logic             mode_single_wr,
   input  logic             rd_start,
   input  logic             wr_start,
   input  logic [COL_W-1:0] start_col,
   input  logic             burst_term,
   output logic             rd_valid,
   output logic             wr_accept,
   output logic [COL_W-1:0] beat_col,
   output logic             burst_done
);
   generate
      if (COL_W < 4) begin : g_bad_col
         $error("COL_W must hold an 8-beat block");
      end
      if (LAT_MAX < 1 || LAT_MAX > 3) begin : g_bad_lat
         $error("LAT_MAX must be 1 to 3");
      end
   endgenerate

   sdr_mode_t        mode;
   logic             rd_launch;
   logic [COL_W-1:0] rd_col;

   sdr_mode_reg #(.LAT_MAX(LAT_MAX)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (mode_load),
      .bl_code   (mode_bl),
      .cl        (mode_cl),
      .ilv       (mode_ilv),
      .single_wr (mode_single_wr),
      .mode      (mode)
   );

   sdr_lat_pipe #(.COL_W(COL_W), .LAT_MAX(LAT_MAX)) u_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .cl         (mode.cl),
      .rd_start   (rd_start),
      .start_col  (start_col),
      .launch     (rd_launch),
      .launch_col (rd_col)
   );

   sdr_beat_seq #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .bl_code    (mode.bl_code),
      .ilv        (mode.ilv),
      .single_wr  (mode.single_wr),
      .rd_launch  (rd_launch),
      .rd_col     (rd_col),
      .wr_start   (wr_start),
      .wr_col     (start_col),
      .term       (burst_term),
      .rd_valid   (rd_valid),
      .wr_accept  (wr_accept),
      .beat_col   (beat_col),
      .burst_done (burst_done)
   );

   p_done_after_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> $past(rd_valid || wr_accept));

endmodule

// File: tb/sim_sdr_beat_timer.sv
`timescale 1ns/1ps
module sim_sdr_beat_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_load = 1'b0;
   logic [2:0] mode_bl = '0;
   logic [1:0] mode_cl = '0;
   logic       mode_ilv = 1'b0, mode_single_wr = 1'b0;
   logic       rd_start = 1'b0, wr_start = 1'b0, burst_term = 1'b0;
   logic [8:0] start_col = '0;
   logic       rd_valid, wr_accept, burst_done;
   logic [8:0] beat_col;

   int n_checks = 0;
   int n_fail   = 0;
   int m_bl = 0, m_cl = 3;
   bit m_ilv = 0, m_sw = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   sdr_beat_timer u0 (
      .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_bl(mode_bl),
      .mode_cl(mode_cl), .mode_ilv(mode_ilv), .mode_single_wr(mode_single_wr),
      .rd_start(rd_start), .wr_start(wr_start), .start_col(start_col),
      .burst_term(burst_term), .rd_valid(rd_valid), .wr_accept(wr_accept),
      .beat_col(beat_col), .burst_done(burst_done)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
      end
   endtask

   function automatic int ecol(input int base, input int i, input int bl, input bit il);
      int len;
      if (bl == 7) return (base + i) % 512;
      len = 1 << bl;
      if (il) return (base & ~(len - 1)) | ((base ^ i) & (len - 1));
      return (base & ~(len - 1)) | ((base + i) % len);
   endfunction

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
   endtask

   task automatic load(input int bl, input int cl, input bit il, input bit sw);
      @(negedge clk);
      mode_load = 1; mode_bl = 3'(bl); mode_cl = 2'(cl);
      mode_ilv = il; mode_single_wr = sw;
      @(negedge clk);
      mode_load = 0;
      if ((bl <= 3 || bl == 7) && cl != 0) begin
         m_bl = bl; m_cl = cl; m_ilv = il; m_sw = sw;
      end
   endtask

   // one command; term_at = beat index that carries burst_term (-1 for none)
   task automatic run(input bit is_wr, input int col, input int term_at, input string tag);
      int len, eff, last_p, b;
      string ctag, wtag;
      bit full;
      full = (m_bl == 7);
      len  = full ? 0 : (1 << m_bl);
      if (is_wr && m_sw) len = 1;
      if (full && !(is_wr && m_sw)) eff = term_at + 1;
      else if (term_at >= 0 && term_at < len) eff = term_at + 1;
      else eff = len;
      ctag = full ? "R7" : (m_ilv ? "R6" : "R5");
      if (tag != "") wtag = tag;
      else if (term_at >= 0 && term_at < eff) wtag = "R8";
      else wtag = is_wr ? (m_sw ? "R9" : "R4") : "R3";
      last_p = is_wr ? eff : (m_cl - 1 + eff);
      for (int p = -1; p <= last_p + 1; p++) begin
         @(negedge clk);
         rd_start  = (p == -1) && !is_wr;
         wr_start  = (p == -1) && is_wr;
         start_col = 9'(col);
         b = is_wr ? p + 1 : p - (m_cl - 1);
         burst_term = (term_at >= 0) && (b == term_at) && (b >= 0) && (b < eff);
         #1;
         if (is_wr) begin
            chk(wtag, "wr_accept", int'(wr_accept), int'(b >= 0 && b < eff));
            chk(wtag, "rd_valid", int'(rd_valid), 0);
         end else begin
            chk(wtag, "rd_valid", int'(rd_valid), int'(p >= 0 && b >= 0 && b < eff));
            chk(wtag, "wr_accept", int'(wr_accept), 0);
         end
         if (b >= 0 && b < eff && (is_wr || p >= 0))
            chk(ctag, "beat_col", int'(beat_col), ecol(col, b, m_bl, m_ilv));
         if (p >= 0)
            chk("R10", "burst_done", int'(burst_done), int'(b == eff));
      end
      @(negedge clk);
      rd_start = 0; wr_start = 0; burst_term = 0;
      idle(2);
   endtask

   initial begin
      #(200000 * 20);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int seed, bls[5];
      seed = $urandom(32'd2024);
      bls = '{0, 1, 2, 3, 7};
      idle(3);
      @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1", "rd_valid", int'(rd_valid), 0);
      chk("R1", "wr_accept", int'(wr_accept), 0);
      chk("R1", "burst_done", int'(burst_done), 0);
      idle(1);
      run(0, 37, -1, "R1");           // default: one beat, latency 3

      // every length and latency, both orders, near the top of the page
      for (int il = 0; il < 2; il++)
         for (int c = 1; c <= 3; c++)
            for (int k = 0; k < 4; k++) begin
               load(k, c, il[0], 0);
               run(0, 9'h1FD, -1, "");
               run(1, 9'h0A6, -1, "");
            end

      // full page wrapping past column 511
      load(7, 2, 1, 0);
      run(0, 9'h1FE, 515, "");
      run(1, 9'h1FC, 6, "");
      // terminate inside an 8-beat burst
      load(3, 3, 0, 0);
      run(0, 5, 2, "");
      run(1, 12, 4, "");
      // burst-read / single-write
      load(3, 1, 1, 1);
      run(1, 21, -1, "");
      run(0, 21, -1, "");
      // rejected loads leave the settings
      load(1, 1, 0, 0);
      load(5, 2, 1, 1);
      run(0, 3, -1, "R2");
      load(3, 0, 1, 1);
      run(1, 3, -1, "R2");

      for (int n = 0; n < 60; n++) begin
         int bl, tat;
         bl = bls[$urandom % 5];
         load(bl, 1 + $urandom % 3, 1'($urandom), 1'($urandom % 4 == 0));
         if (bl == 7) tat = $urandom % 24;
         else tat = ($urandom % 3 == 0) ? int'($urandom % 8) : -1;
         run(1'($urandom), $urandom % 512, tat, "");
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule